// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block sits between a framebuffer fetch engine and a display pipeline. It accepts 32-bit words read from pixel memory and turns each word into a run of 24-bit RGB pixels. One pixel comes out per cycle when the consumer is ready. A 3-bit mode selects the pixel depth and encoding: 1, 2, 4 or 8 bits per palette index, 16-bit direct colour in several layouts, 12-bit 4:4:4, or 32-bit direct colour. Three flags set the order in which pixels are taken from the word and the order of the colour channels. For palette modes the block puts the index on a lookup port and passes the returned colour on to the output.

For 16-bit colour the parameter `EXTENDED` selects between two variants. The extended variant has dedicated mode codes for 5:5:5:1, 5:6:5 and 4:4:4. In the basic variant every 16-bit mode code gives the same kind of pixel, and an external two-bit selector decides how those pixels are laid out. The block also reports, as a combinational output, how many bytes one display line occupies for the current column count and depth.

Both streams follow valid/ready rules. A word is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the unpacker is idle, and in the cycle in which the last pixel of the held word is being taken. A pixel is transferred in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pending pixel and its palette index stay fixed. The mode, the order and swap flags and the 16-bit selector are captured when a word is accepted.

Top module: `fb_pixel_unpacker`

## Requirements
- R1: The bits per pixel b depend on `mode_sel`: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4, 6 and 7 give 16, and 5 gives 32. Each accepted word yields exactly 32/b pixels. After the last pixel, `out_valid` drops unless a new word was accepted in that cycle.
- R2: Let n = 32/b. With both order flags clear, pixel k is taken from word bits [b*k +: b]. With `be_byte` set, pixel k is taken from bits [b*(n-1-k) +: b], so the most significant pixel comes first; `be_byte` takes priority over `be_pix`. With only `be_pix` set and b < 8, bytes are taken least significant first, and within each byte the most significant pixel comes first. For b ≥ 8, `be_pix` alone has no effect.
- R3: In modes 0 to 3, `pal_idx` carries the pixel bits, zero-extended to 8 bits. The colour on `pal_rgb` forms the output, with field f2 = `pal_rgb[23:16]`, f1 = `pal_rgb[15:8]` and f0 = `pal_rgb[7:0]`.
- R4: Each direct-colour format has three fields, f0 (lowest) to f2. For 32 bpp they are bits [7:0], [15:8] and [23:16]. For 5:5:5:1 they are [4:0], [9:5] and [14:10], and bit 15 is ignored. For 5:6:5 they are [4:0], [10:5] and [15:11]. For 4:4:4 they are [3:0], [7:4] and [11:8]. Each field is widened to 8 bits by appending zeros below it. In the extended variant, mode 4 is 5:5:5:1, mode 6 is 5:6:5 and mode 7 is 4:4:4.
- R5: With `bgr_sel` high, `out_rgb` is {f2,f1,f0}. With `bgr_sel` low, it is {f0,f1,f2}.
- R6: In the basic variant, modes 4, 6 and 7 are all 16-bit and `fmt16_mux` picks the layout. Value 1 gives 5:5:5:1 and follows R5. Value 3 gives 5:6:5, always as {f2,f1,f0}. Values 0 and 2 give 5:6:5 and follow R5.
- R7: `line_bytes` equals floor(`cols` * b / 8). It is computed combinationally from the current pins.
- R8: `in_ready` is high when the unpacker is idle, or when the last pixel of the held word is taken in that cycle; it is low otherwise. While `out_valid` is high and `out_ready` is low, `out_rgb` and `pal_idx` hold their values.
- R9: While reset is asserted, `out_valid` is low and `in_ready` is high.
- R10: Changing the mode, order, swap or selector pins after a word has been accepted has no effect on the pixels of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Pixel depth and encoding code |
| bgr_sel | input | 1 | High: f2 goes to the top output byte; low: red and blue are swapped |
| be_byte | input | 1 | Big-endian order of pixels within the word |
| be_pix | input | 1 | Big-endian order of pixels within each byte |
| fmt16_mux | input | 2 | 16-bit layout selector (basic variant only) |
| cols | input | COL_W | Pixels per display line |
| line_bytes | output | COL_W+2 | Bytes per display line |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unpacker can take a word |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_rgb | output | 24 | Output pixel |
| pal_idx | output | 8 | Palette index for the pending pixel |
| pal_rgb | input | 24 | Palette colour returned for `pal_idx` |

## Verification
The hardest case to reach from the ports is a configuration change while a word is still being unpacked, with the consumer stalling at the same time. The latched copy only shows its worth when the pins differ from it mid-word. The stimulus therefore inverts several configuration pins right after every acceptance. It sweeps every mode, both swap settings, all four selector values and all four combinations of the order flags, including both flags set. A pseudo-random pattern withdraws `out_ready` on some pixels, so output holding is checked at every pixel position, including the last one.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 5;
  localparam int RGB_W  = 24;

  typedef enum logic [2:0] {
    FMT_IDX  = 3'd0,
    FMT_5551 = 3'd1,
    FMT_565  = 3'd2,
    FMT_444  = 3'd3,
    FMT_888  = 3'd4
  } pix_fmt_e;

  typedef enum logic [1:0] {
    ORD_LL = 2'd0,
    ORD_BB = 2'd1,
    ORD_LB = 2'd2
  } ord_e;

  typedef struct packed {
    logic [2:0] wlog;   // log2 of bits per pixel
    pix_fmt_e   fmt;
    ord_e       ord;
    logic       swap;   // 1: f0 lands in the top output byte
  } dec_cfg_t;
endpackage

// File: rtl/fbu_mode_decode.sv
module fbu_mode_decode
  import fbu_pkg::*;
#(
  parameter int COL_W    = 12,
  parameter int EXTENDED = 1
) (
  input  logic [2:0]       mode_sel,
  input  logic             bgr_sel,
  input  logic             be_byte,
  input  logic             be_pix,
  input  logic [1:0]       fmt16_mux,
  input  logic [COL_W-1:0] cols,
  output dec_cfg_t         cfg,
  output logic [COL_W+1:0] line_bytes
);
  localparam bit EXT = (EXTENDED != 0);

  always_comb begin
    cfg.swap = ~bgr_sel;
    cfg.ord  = be_byte ? ORD_BB : (be_pix ? ORD_LB : ORD_LL);
    cfg.wlog = 3'd4;
    cfg.fmt  = FMT_565;
    case (mode_sel)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        cfg.wlog = mode_sel;
        cfg.fmt  = FMT_IDX;
      end
      3'd5: begin
        cfg.wlog = 3'd5;
        cfg.fmt  = FMT_888;
      end
      default: begin
        if (EXT) begin
          if (mode_sel == 3'd6)      cfg.fmt = FMT_565;
          else if (mode_sel == 3'd7) cfg.fmt = FMT_444;
          else                       cfg.fmt = FMT_5551;
        end else begin
          case (fmt16_mux)
            2'd1:    cfg.fmt = FMT_5551;
            2'd3: begin
              cfg.fmt  = FMT_565;
              cfg.swap = 1'b0;
            end
            default: cfg.fmt = FMT_565;
          endcase
        end
      end
    endcase
  end

  logic [COL_W+1:0] cols_w;
  assign cols_w = {2'b00, cols};

  always_comb begin
    if (cfg.wlog < 3'd3) line_bytes = cols_w >> (3'd3 - cfg.wlog);
    else                 line_bytes = cols_w << (cfg.wlog - 3'd3);
  end
endmodule

// File: rtl/fbu_slot_select.sv
module fbu_slot_select
  import fbu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [2:0]        wlog,
  input  ord_e              ord,
  output logic [WORD_W-1:0] raw
);
  logic [CNT_W:0]   npix;
  logic [CNT_W-1:0] flip, slot, sh;

  assign npix = (CNT_W+1)'(WORD_W) >> wlog;

  always_comb begin
    case (ord)
      ORD_BB:  flip = CNT_W'(npix - 1'b1);
      ORD_LB:  flip = (wlog < 3'd3) ? CNT_W'((4'd8 >> wlog) - 4'd1) : '0;
      default: flip = '0;
    endcase
  end

  assign slot = cnt ^ flip;
  assign sh   = slot << wlog;
  assign raw  = word >> sh;
endmodule

// File: rtl/fbu_color_expand.sv
module fbu_color_expand
  import fbu_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  logic [2:0]        wlog,
  input  pix_fmt_e          fmt,
  input  logic              swap,
  input  logic [RGB_W-1:0]  pal_rgb,
  output logic [7:0]        pal_idx,
  output logic [RGB_W-1:0]  rgb
);
  logic [7:0] mask;
  logic [7:0] f0, f1, f2;

  always_comb begin
    case (wlog)
      3'd0:    mask = 8'h01;
      3'd1:    mask = 8'h03;
      3'd2:    mask = 8'h0F;
      default: mask = 8'hFF;
    endcase
  end

  assign pal_idx = (fmt == FMT_IDX) ? (raw[7:0] & mask) : 8'h00;

  always_comb begin
    case (fmt)
      FMT_IDX: {f2, f1, f0} = pal_rgb;
      FMT_5551: begin
        f0 = {raw[4:0],   3'b000};
        f1 = {raw[9:5],   3'b000};
        f2 = {raw[14:10], 3'b000};
      end
      FMT_565: begin
        f0 = {raw[4:0],   3'b000};
        f1 = {raw[10:5],  2'b00};
        f2 = {raw[15:11], 3'b000};
      end
      FMT_444: begin
        f0 = {raw[3:0],  4'h0};
        f1 = {raw[7:4],  4'h0};
        f2 = {raw[11:8], 4'h0};
      end
      default: begin
        f0 = raw[7:0];
        f1 = raw[15:8];
        f2 = raw[23:16];
      end
    endcase
  end

  assign rgb = swap ? {f0, f1, f2} : {f2, f1, f0};
endmodule

// File: rtl/fb_pixel_unpacker.sv
module fb_pixel_unpacker
  import fbu_pkg::*;
#(
  parameter int COL_W    = 12,
  parameter int EXTENDED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              bgr_sel,
  input  logic              be_byte,
  input  logic              be_pix,
  input  logic [1:0]        fmt16_mux,
  input  logic [COL_W-1:0]  cols,
  output logic [COL_W+1:0]  line_bytes,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RGB_W-1:0]  out_rgb,
  output logic [7:0]        pal_idx,
  input  logic [RGB_W-1:0]  pal_rgb
);
  dec_cfg_t          cfg_d, cfg_q;
  logic              busy;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt, last_idx;
  logic [WORD_W-1:0] raw_px;
  logic              last, accept, fire;

  fbu_mode_decode #(.COL_W(COL_W), .EXTENDED(EXTENDED)) u_dec (
    .mode_sel(mode_sel), .bgr_sel(bgr_sel), .be_byte(be_byte), .be_pix(be_pix),
    .fmt16_mux(fmt16_mux), .cols(cols), .cfg(cfg_d), .line_bytes(line_bytes)
  );

  fbu_slot_select u_sel (
    .word(word_q), .cnt(cnt), .wlog(cfg_q.wlog), .ord(cfg_q.ord), .raw(raw_px)
  );

  fbu_color_expand u_exp (
    .raw(raw_px), .wlog(cfg_q.wlog), .fmt(cfg_q.fmt), .swap(cfg_q.swap),
    .pal_rgb(pal_rgb), .pal_idx(pal_idx), .rgb(out_rgb)
  );

  assign last_idx  = CNT_W'(((CNT_W+1)'(WORD_W) >> cfg_q.wlog) - 1'b1);
  assign last      = (cnt == last_idx);
  assign out_valid = busy;
  assign fire      = busy && out_ready;
  assign in_ready  = !busy || (out_ready && last);
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      word_q <= '0;
      cfg_q  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      word_q <= in_word;
      cfg_q  <= cfg_d;
    end else if (fire) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cnt <= last_idx);  // R1
  AST_FRESH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && cnt == '0));  // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(pal_idx) && $stable(raw_px)));  // R8
  AST_NO_EARLY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid) |-> (out_ready && cnt == last_idx));  // R8
  AST_WIDE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_d.wlog == 3'd5) |-> (line_bytes[1:0] == 2'b00));  // R7
  AST_ONE_BIT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_q.fmt == FMT_IDX && cfg_q.wlog == 3'd0) |-> (pal_idx[7:1] == 7'd0));  // R3
endmodule

// File: tb/fb_pixel_unpacker_test.sv
module fb_pixel_unpacker_test;
  localparam int COL_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic bgr_sel = 1'b0, be_byte = 1'b0, be_pix = 1'b0;
  logic [1:0] fmt16_mux = 2'd0;
  logic [COL_W-1:0] cols = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_word = '0;

  logic [COL_W+1:0] lb_a, lb_b;
  logic rdy_a, rdy_b, ov_a, ov_b;
  logic [23:0] rgb_a, rgb_b, pal_a, pal_b;
  logic [7:0] idx_a, idx_b;

  int checks = 0;
  int bad = 0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  function automatic logic [23:0] pal_of(input logic [7:0] i);
    return {i, i ^ 8'hA5, ~i};
  endfunction

  assign pal_a = pal_of(idx_a);
  assign pal_b = pal_of(idx_b);

  fb_pixel_unpacker #(.COL_W(COL_W), .EXTENDED(1)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bgr_sel(bgr_sel),
    .be_byte(be_byte), .be_pix(be_pix), .fmt16_mux(fmt16_mux), .cols(cols),
    .line_bytes(lb_a), .in_valid(in_valid), .in_ready(rdy_a), .in_word(in_word),
    .out_valid(ov_a), .out_ready(out_ready), .out_rgb(rgb_a), .pal_idx(idx_a),
    .pal_rgb(pal_a));

  fb_pixel_unpacker #(.COL_W(COL_W), .EXTENDED(0)) uut_base (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bgr_sel(bgr_sel),
    .be_byte(be_byte), .be_pix(be_pix), .fmt16_mux(fmt16_mux), .cols(cols),
    .line_bytes(lb_b), .in_valid(in_valid), .in_ready(rdy_b), .in_word(in_word),
    .out_valid(ov_b), .out_ready(out_ready), .out_rgb(rgb_b), .pal_idx(idx_b),
    .pal_rgb(pal_b));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bits_of(input int mode);
    if (mode <= 3) return 1 << mode;
    if (mode == 5) return 32;
    return 16;
  endfunction

  // Reference pixel: R2 ordering, R3/R4/R6 field layouts, R5 channel swap.
  function automatic logic [23:0] model(input bit ext, input int mode, input bit bgr,
      input bit beb, input bit bep, input int mux, input logic [31:0] w, input int k);
    int b, n, s, per, fm;
    logic [31:0] p;
    logic [7:0] f0, f1, f2;
    bit sw;
    b = bits_of(mode);
    n = 32 / b;
    if (beb) s = n - 1 - k;
    else if (bep && b < 8) begin
      per = 8 / b;
      s = (k / per) * per + (per - 1 - (k % per));
    end else s = k;
    p = w >> (s * b);
    if (b < 32) p = p & ((32'd1 << b) - 32'd1);
    sw = !bgr;
    if (mode <= 3) fm = 0;
    else if (mode == 5) fm = 4;
    else if (ext) fm = (mode == 4) ? 1 : ((mode == 6) ? 2 : 3);
    else begin
      fm = (mux == 1) ? 1 : 2;
      if (mux == 3) sw = 1'b0;
    end
    case (fm)
      0: {f2, f1, f0} = pal_of(p[7:0]);
      1: begin f0 = {p[4:0], 3'b0}; f1 = {p[9:5], 3'b0}; f2 = {p[14:10], 3'b0}; end
      2: begin f0 = {p[4:0], 3'b0}; f1 = {p[10:5], 2'b0}; f2 = {p[15:11], 3'b0}; end
      3: begin f0 = {p[3:0], 4'h0}; f1 = {p[7:4], 4'h0}; f2 = {p[11:8], 4'h0}; end
      default: begin f0 = p[7:0]; f1 = p[15:8]; f2 = p[23:16]; end
    endcase
    return sw ? {f0, f1, f2} : {f2, f1, f0};
  endfunction

  function automatic string tag_of(input bit ext, input int mode);
    if (mode <= 3) return "R3 R10";
    if (!ext && mode != 5) return "R6 R10";
    return "R4 R10";
  endfunction

  task automatic run_word(input int mode, input bit beb, input bit bep, input bit bgr,
      input int mux, input int c, input logic [31:0] w);
    int n, lbx;
    bit stall;
    logic [23:0] hold;
    mode_sel = 3'(mode); be_byte = beb; be_pix = bep; bgr_sel = bgr;
    fmt16_mux = 2'(mux); cols = COL_W'(c);
    in_valid = 1'b1; in_word = w;
    #1;
    chk(rdy_a && rdy_b, "R8 idle ready", {30'd0, rdy_a, rdy_b}, 32'd3);
    chk(!ov_a && !ov_b, "R1 no extra pixel", {30'd0, ov_a, ov_b}, 32'd0);
    lbx = (c * bits_of(mode)) / 8;
    chk(lb_a == (COL_W+2)'(lbx), "R7 ext", 32'(lb_a), 32'(lbx));
    chk(lb_b == (COL_W+2)'(lbx), "R7 base", 32'(lb_b), 32'(lbx));
    @(negedge clk);
    in_valid = 1'b0;
    // disturb configuration pins; latched copy must govern (R10)
    mode_sel = mode_sel ^ 3'd5; bgr_sel = ~bgr_sel; be_byte = ~be_byte;
    fmt16_mux = fmt16_mux ^ 2'd2;
    n = 32 / bits_of(mode);
    for (int k = 0; k < n; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      stall = lf[0] & lf[3];
      if (stall) begin
        out_ready = 1'b0;
        #1;
        chk(ov_a && ov_b, "R8 valid under stall", {30'd0, ov_a, ov_b}, 32'd3);
        chk(!rdy_a, "R8 ready low under stall", {31'd0, rdy_a}, 32'd0);
        hold = rgb_a;
        @(negedge clk);
        #1;
        chk(ov_a && rgb_a == hold, "R8 hold", {8'd0, rgb_a}, {8'd0, hold});
      end
      out_ready = 1'b1;
      #1;
      chk(rgb_a == model(1'b1, mode, bgr, beb, bep, mux, w, k), tag_of(1'b1, mode),
          {8'd0, rgb_a}, {8'd0, model(1'b1, mode, bgr, beb, bep, mux, w, k)});
      chk(rgb_b == model(1'b0, mode, bgr, beb, bep, mux, w, k), tag_of(1'b0, mode),
          {8'd0, rgb_b}, {8'd0, model(1'b0, mode, bgr, beb, bep, mux, w, k)});
      chk(rdy_a == (k == n - 1), "R8 ready at last", {31'd0, rdy_a}, {31'd0, k == n - 1});
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int combo;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    #1;
    chk(!ov_a && !ov_b, "R9 valid low", {30'd0, ov_a, ov_b}, 32'd0);
    chk(rdy_a && rdy_b, "R9 ready high", {30'd0, rdy_a, rdy_b}, 32'd3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    combo = 0;
    for (int m = 0; m < 8; m++)
      for (int o = 0; o < 4; o++)
        for (int g = 0; g < 2; g++)
          for (int x = 0; x < 4; x++) begin
            combo++;
            for (int wi = 0; wi < 2; wi++) begin
              w = (32'(combo) * 32'h9E3779B9) ^ (wi != 0 ? 32'hF0F0_3C3C : 32'h0123_4567);
              run_word(m, o[1], o[0], g[0], x, (combo * 37 + 8) % 4096, w);
            end
          end
    #1;
    chk(!ov_a && !ov_b, "R1 drained", {30'd0, ov_a, ov_b}, 32'd0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule